// File: doc/BRIEF.md
# UART Receive Path with Line Status Tracking

This block is the receive side of a serial port together with a small transmit holding/shift pair, a receive FIFO and a read-only line status byte. A receiver running at sixteen samples per bit turns the serial line into characters. The frame is fixed: one start bit, eight data bits sent least significant bit first, one stop bit and no parity. Each character goes into the receive FIFO with its own framing and break flags. The status byte always describes the character at the FIFO head, so software learns about an error on the same read that returns the faulty character.

A three-bit register port gives access to the block. Address 0 pops the receive buffer on read and loads the transmit holding register on write. Address 5 returns the line status. Reading the status clears its sticky bits. The receiver FSM has five states. RX_IDLE moves to RX_START on a low line. RX_START returns to RX_IDLE if the midpoint sample is high, and moves on to RX_DATA if it is low. RX_DATA moves to RX_STOP after eight bits. RX_STOP can go three ways: to RX_IDLE on a good stop bit, back to RX_DATA on a framing error (resync), or to RX_BREAK_WAIT on a break. RX_BREAK_WAIT returns to RX_IDLE once the line goes high. The transmitter FSM has two states. TX_IDLE moves to TX_SHIFT when the holding register is full. TX_SHIFT returns to TX_IDLE after ten bit times.

Top module: `uls_top`

## Requirements
- R1: After reset the status byte reads 0x60 (bit 5 and bit 6 set, all other bits 0), the receive buffer reads 0 and `txd` is 1.
- R2: A received frame (low start bit, 8 data bits LSB first, stop bit) enters the FIFO. Each bit is sampled at the 8th of its 16 sample ticks. Status bit 0 is 1 while the FIFO holds an entry. A read at address 0 returns the head data and removes it.
- R3: A low pulse on `rxd` that has gone high again by the start bit's midpoint sample is ignored and produces no character.
- R4: If the stop bit is sampled 0 and the data is not all zero, the character is stored with its framing flag. Status bit 3 shows that flag for the head entry.
- R5: After a framing error, the low stop bit serves as the start bit of the next character, and that character's data bits follow at once.
- R6: If start, data and stop bits are all 0, a single entry of 0x00 is stored with its break flag, which status bit 4 shows for the head entry. No further characters are received until `rxd` returns to 1.
- R7: A status read clears bits 3 and 4 for the current head entry. They stay cleared until the head entry changes.
- R8: Status bit 7 is set when an entry with a framing or break flag is loaded into the FIFO. A status read clears it only if the FIFO holds no such entry at the time of the read.
- R9: A character that arrives while the FIFO is full and not being read in that cycle is dropped, and status bit 1 is set. A status read clears bit 1.
- R10: Status bit 5 is 1 while the transmit holding register is empty and is cleared by a write to address 0. The held byte moves into the idle shift register one cycle later.
- R11: Status bit 6 is 1 only when both the holding and shift registers are empty. `txd` sends the same frame format as R2, holding each bit for 16 sample ticks.
- R12: Status bit 2 reads 0, reads at addresses other than 0 and 5 return 0, and writes to addresses other than 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| addr | input | 3 | Register address (0 buffer, 5 status) |
| rd_en | input | 1 | Read strobe (pops at 0, clears sticky bits at 5) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data for the holding register |
| rd_data | output | 8 | Read data for the selected address |

## Verification
The bench builds the block with a FIFO depth of 4 and one clock per sample tick. With these values every bit time is exactly 16 clocks, so frame timing can be predicted to the cycle. The FIFO fills after four characters, which makes overrun and drop behaviour reachable in a short run. Feeding `txd` back to `rxd` lets transmit framing and receive framing be compared against each other at the same bit rate.

// File: rtl/uls_pkg.sv
package uls_pkg;
    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = DATA_W + 2;
    localparam logic [2:0] ADDR_BUF  = 3'd0;
    localparam logic [2:0] ADDR_STAT = 3'd5;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_BREAK_WAIT
    } rx_state_t;

    typedef enum logic {
        TX_IDLE,
        TX_SHIFT
    } tx_state_t;
endpackage

// File: rtl/uls_rx.sv
module uls_rx
    import uls_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rxd,
    output logic      push,
    output rx_entry_t push_entry
);
    localparam int CW   = $clog2(OVS);
    localparam int BW   = $clog2(DATA_W);
    localparam logic [CW-1:0] HALF_M1 = CW'(OVS/2 - 1);
    localparam logic [CW-1:0] LAST    = CW'(OVS - 1);
    localparam logic [BW-1:0] BIT_END = BW'(DATA_W - 1);

    logic [1:0]        sync_q;
    logic              rx_s;
    rx_state_t         state_q, state_n;
    logic [CW-1:0]     cnt_q, cnt_n;
    logic [BW-1:0]     bit_q, bit_n;
    logic [DATA_W-1:0] sh_q, sh_n;
    logic              at_last;

    assign rx_s    = sync_q[1];
    assign at_last = tick && (cnt_q == LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= 2'b11;
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
        end else begin
            sync_q  <= {sync_q[0], rxd};
            state_q <= state_n;
            cnt_q   <= cnt_n;
            bit_q   <= bit_n;
            sh_q    <= sh_n;
        end
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        bit_n   = bit_q;
        sh_n    = sh_q;
        unique case (state_q)
            RX_IDLE: begin
                if (!rx_s) begin
                    state_n = RX_START;
                    cnt_n   = '0;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (cnt_q == HALF_M1) begin
                        cnt_n   = '0;
                        bit_n   = '0;
                        state_n = rx_s ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (at_last) begin
                    cnt_n = '0;
                    sh_n  = {rx_s, sh_q[DATA_W-1:1]};
                    if (bit_q == BIT_END) state_n = RX_STOP;
                    else                  bit_n   = bit_q + 1'b1;
                end else if (tick) begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            RX_STOP: begin
                if (at_last) begin
                    cnt_n = '0;
                    bit_n = '0;
                    if (rx_s)            state_n = RX_IDLE;
                    else if (sh_q == '0) state_n = RX_BREAK_WAIT;
                    else                 state_n = RX_DATA;
                end else if (tick) begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            RX_BREAK_WAIT: begin
                if (rx_s) state_n = RX_IDLE;
            end
            default: state_n = RX_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        push            = (state_q == RX_STOP) && at_last;
        push_entry.data = sh_q;
        push_entry.ferr = !rx_s && (sh_q != '0);
        push_entry.brk  = !rx_s && (sh_q == '0);
    end

    // R6
    break_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_BREAK_WAIT && !rx_s) |=> (state_q == RX_BREAK_WAIT));

    // R5
    resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_entry.ferr) |=> (state_q == RX_DATA && cnt_q == '0));
endmodule

// File: rtl/uls_fifo.sv
module uls_fifo
    import uls_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  rx_entry_t                  wentry,
    input  logic                       pop,
    output rx_entry_t                  head,
    output logic                       empty,
    output logic                       full,
    output logic                       accept,
    output logic                       drop,
    output logic [$clog2(DEPTH+1)-1:0] err_cnt
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_END = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    rx_entry_t     mem_q [DEPTH];
    logic [AW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q, errs_q;
    logic          pop_ok, w_err, h_err;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == FULL_CNT);
    assign pop_ok  = pop && !empty;
    assign accept  = push && (!full || pop_ok);
    assign drop    = push && !accept;
    assign head    = mem_q[rd_q];
    assign err_cnt = errs_q;
    assign w_err   = wentry.ferr || wentry.brk;
    assign h_err   = head.ferr || head.brk;

    function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
        return (p == PTR_END) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (accept) mem_q[wr_q] <= wentry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q   <= '0;
            wr_q   <= '0;
            cnt_q  <= '0;
            errs_q <= '0;
        end else begin
            if (accept) wr_q <= adv(wr_q);
            if (pop_ok) rd_q <= adv(rd_q);
            cnt_q  <= cnt_q + CW'(accept) - CW'(pop_ok);
            errs_q <= errs_q + CW'(accept && w_err) - CW'(pop_ok && h_err);
        end
    end

    // R9
    drop_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (cnt_q == $past(cnt_q)));

    // R2
    pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !empty) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/uls_tx.sv
module uls_tx
    import uls_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              thre,
    output logic              temt,
    output logic              txd
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(FRAME_BITS);
    localparam logic [CW-1:0] LAST    = CW'(OVS - 1);
    localparam logic [BW-1:0] BIT_END = BW'(FRAME_BITS - 1);

    tx_state_t             state_q, state_n;
    logic [DATA_W-1:0]     hold_q;
    logic                  hfull_q, hfull_n, xfer;
    logic [FRAME_BITS-1:0] frame_q, frame_n;
    logic [CW-1:0]         cnt_q, cnt_n;
    logic [BW-1:0]         bit_q, bit_n;
    logic                  txd_q;

    assign xfer    = hfull_q && (state_q == TX_IDLE);
    assign hfull_n = (hfull_q && !xfer) || wr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            hold_q  <= '0;
            hfull_q <= 1'b0;
            frame_q <= '1;
            cnt_q   <= '0;
            bit_q   <= '0;
            txd_q   <= 1'b1;
        end else begin
            state_q <= state_n;
            hfull_q <= hfull_n;
            if (wr) hold_q <= wr_data;
            frame_q <= frame_n;
            cnt_q   <= cnt_n;
            bit_q   <= bit_n;
            txd_q   <= (state_n == TX_SHIFT) ? frame_n[0] : 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        frame_n = frame_q;
        cnt_n   = cnt_q;
        bit_n   = bit_q;
        unique case (state_q)
            TX_IDLE: begin
                if (xfer) begin
                    state_n = TX_SHIFT;
                    frame_n = {1'b1, hold_q, 1'b0};
                    cnt_n   = '0;
                    bit_n   = '0;
                end
            end
            TX_SHIFT: begin
                if (tick) begin
                    if (cnt_q == LAST) begin
                        cnt_n = '0;
                        if (bit_q == BIT_END) begin
                            state_n = TX_IDLE;
                        end else begin
                            bit_n   = bit_q + 1'b1;
                            frame_n = {1'b1, frame_q[FRAME_BITS-1:1]};
                        end
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            default: state_n = TX_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        thre = !hfull_q;
        temt = !hfull_q && (state_q == TX_IDLE);
        txd  = txd_q;
    end

    // R10
    xfer_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hfull_q && state_q == TX_IDLE) |=> (state_q == TX_SHIFT && !txd_q));
endmodule

// File: rtl/uls_top.sv
module uls_top
    import uls_pkg::*;
#(
    parameter int OVS             = 16,
    parameter int FIFO_DEPTH      = 16,
    parameter int CLKS_PER_SAMPLE = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    output logic       txd,
    input  logic [2:0] addr,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data
);
    localparam int EW = $clog2(FIFO_DEPTH + 1);

    logic          tick;
    logic          rx_push;
    rx_entry_t     rx_entry, head;
    logic          empty, full, accept, drop;
    logic [EW-1:0] err_cnt;
    logic          stat_rd, buf_rd, thr_wr, pop_eff, head_chg;
    logic          ack_q, ovr_q, ferr_q;
    logic          thre, temt;
    logic [7:0]    lsr;

    generate
        if (CLKS_PER_SAMPLE == 1) begin : g_tick_every
            assign tick = 1'b1;
        end else begin : g_tick_div
            localparam int PW = $clog2(CLKS_PER_SAMPLE);
            localparam logic [PW-1:0] PEND = PW'(CLKS_PER_SAMPLE - 1);
            logic [PW-1:0] pre_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)            pre_q <= '0;
                else if (pre_q == PEND) pre_q <= '0;
                else                    pre_q <= pre_q + 1'b1;
            end
            assign tick = (pre_q == PEND);
        end
    endgenerate

    uls_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .push(rx_push), .push_entry(rx_entry)
    );

    uls_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wentry(rx_entry),
        .pop(buf_rd), .head(head), .empty(empty), .full(full),
        .accept(accept), .drop(drop), .err_cnt(err_cnt)
    );

    uls_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr(thr_wr),
        .wr_data(wr_data), .thre(thre), .temt(temt), .txd(txd)
    );

    assign stat_rd  = rd_en && (addr == ADDR_STAT);
    assign buf_rd   = rd_en && (addr == ADDR_BUF);
    assign thr_wr   = wr_en && (addr == ADDR_BUF);
    assign pop_eff  = buf_rd && !empty;
    assign head_chg = pop_eff || (rx_push && empty);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q  <= 1'b0;
            ovr_q  <= 1'b0;
            ferr_q <= 1'b0;
        end else begin
            if (head_chg)     ack_q <= 1'b0;
            else if (stat_rd) ack_q <= 1'b1;
            ovr_q  <= drop || (ovr_q && !stat_rd);
            ferr_q <= (accept && (rx_entry.ferr || rx_entry.brk)) ||
                      (ferr_q && !(stat_rd && err_cnt == '0));
        end
    end

    always_comb begin
        lsr    = '0;
        lsr[0] = !empty;
        lsr[1] = ovr_q;
        lsr[3] = !empty && head.ferr && !ack_q;
        lsr[4] = !empty && head.brk && !ack_q;
        lsr[5] = thre;
        lsr[6] = temt;
        lsr[7] = ferr_q;
        unique case (addr)
            ADDR_BUF:  rd_data = empty ? '0 : head.data;
            ADDR_STAT: rd_data = lsr;
            default:   rd_data = '0;
        endcase
    end

    // R7
    ack_hides_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !head_chg) |=> (!lsr[3] && !lsr[4]));

    // R8
    fifo_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr[7] && err_cnt != '0) |=> lsr[7]);
endmodule

// File: tb/tb_uls_top.sv
module tb_uls_top;
    localparam int OVS   = 16;
    localparam int DEPTH = 4;
    localparam int LAT   = 3 + OVS/2 + 9*OVS;
    localparam int TXLEN = 10*OVS;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       rxd_drv = 1;
    logic       loop = 0;
    logic       rxd, txd;
    logic [2:0] addr = 3'd5;
    logic       rd_en = 0, wr_en = 0;
    logic [7:0] wr_data = 0, rd_data;

    int checks = 0, fails = 0, cyc = 0;

    assign rxd = loop ? txd : rxd_drv;

    uls_top #(.OVS(OVS), .FIFO_DEPTH(DEPTH), .CLKS_PER_SAMPLE(1)) dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd), .addr(addr),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    // reference model state
    int       pend_cyc[$];
    bit [9:0] pend_ent[$];
    bit [9:0] mq[$];
    bit       m_ack, m_ovr, m_ferr, m_hfull;
    bit [7:0] m_hold, m_shift;
    int       m_busy;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit [7:0] m_status();
        bit [7:0] s = 0;
        s[0] = mq.size() != 0;
        s[1] = m_ovr;
        s[3] = mq.size() != 0 && mq[0][8] && !m_ack;
        s[4] = mq.size() != 0 && mq[0][9] && !m_ack;
        s[5] = !m_hfull;
        s[6] = !m_hfull && m_busy == 0;
        s[7] = m_ferr;
        return s;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            mq.delete(); m_ack = 0; m_ovr = 0; m_ferr = 0; m_hfull = 0; m_busy = 0;
        end else begin
            bit stat_rd, buf_rd, thr_wr, pop_eff, push, accept, drop, hchg, xfer;
            bit [9:0] ent;
            int errs;
            stat_rd = rd_en && addr == 3'd5;
            buf_rd  = rd_en && addr == 3'd0;
            thr_wr  = wr_en && addr == 3'd0;
            errs = 0;
            foreach (mq[i]) if (mq[i][9:8] != 0) errs++;
            pop_eff = buf_rd && mq.size() != 0;
            push = pend_cyc.size() != 0 && pend_cyc[0] == cyc;
            ent = push ? pend_ent[0] : 10'd0;
            if (push) begin void'(pend_cyc.pop_front()); void'(pend_ent.pop_front()); end
            accept = push && (mq.size() < DEPTH || pop_eff);
            drop   = push && !accept;
            hchg   = pop_eff || (push && mq.size() == 0);
            m_ferr = (accept && ent[9:8] != 0) || (m_ferr && !(stat_rd && errs == 0));
            m_ovr  = drop || (m_ovr && !stat_rd);
            if (hchg) m_ack = 0; else if (stat_rd) m_ack = 1;
            if (pop_eff) void'(mq.pop_front());
            if (accept) mq.push_back(ent);
            xfer = m_hfull && m_busy == 0;
            if (xfer) begin
                m_busy = TXLEN; m_shift = m_hold;
                if (loop) begin pend_cyc.push_back(cyc + LAT); pend_ent.push_back({2'b00, m_hold}); end
            end else if (m_busy > 0) m_busy--;
            m_hfull = (m_hfull && !xfer) || thr_wr;
            if (thr_wr) m_hold = wr_data;
        end
    end

    // per-clock comparison, away from the edge
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            bit [7:0] exp, st;
            bit [9:0] fr;
            bit etx;
            st = m_status();
            if (addr == 3'd5) begin
                exp = st;
                for (int b = 0; b < 8; b++) begin
                    string tag;
                    case (b)
                        0: tag = "R2 bit0"; 1: tag = "R9 bit1"; 2: tag = "R12 bit2";
                        3: tag = "R4 bit3"; 4: tag = "R6 bit4"; 5: tag = "R10 bit5";
                        6: tag = "R11 bit6"; default: tag = "R8 bit7";
                    endcase
                    chk(rd_data[b] == exp[b], tag, rd_data[b], exp[b]);
                end
            end else begin
                exp = (addr == 3'd0 && mq.size() != 0) ? mq[0][7:0] : 8'd0;
                chk(rd_data == exp, addr == 3'd0 ? "R2 buffer" : "R12 other addr", rd_data, exp);
            end
            fr  = {1'b1, m_shift, 1'b0};
            etx = (m_busy > 0) ? fr[(TXLEN - m_busy) / OVS] : 1'b1;
            chk(txd == etx, "R11 txd", txd, etx);
        end
    end

    task automatic drive_bits(input bit [31:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            rxd_drv = bits[i];
            repeat (OVS) @(negedge clk);
        end
        rxd_drv = 1;
    endtask

    // one frame; stop bit value chooses good frame or framing error
    task automatic send_char(input bit [7:0] d, input bit stop);
        @(negedge clk);
        pend_cyc.push_back(cyc + LAT);
        pend_ent.push_back({1'b0, !stop, d});
        drive_bits({22'd0, stop, d, 1'b0}, 10);
    endtask

    task automatic reg_read(input bit [2:0] a, output bit [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1;
        #2 v = rd_data;
        @(negedge clk);
        rd_en = 0; addr = 3'd5;
    endtask

    task automatic reg_write(input bit [2:0] a, input bit [7:0] d);
        @(negedge clk);
        addr = a; wr_en = 1; wr_data = d;
        @(negedge clk);
        wr_en = 0; addr = 3'd5;
    endtask

    initial begin
        bit [7:0] v;
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        bit [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        #2 chk(rd_data == 8'h60, "R1 status", rd_data, 8'h60);
        chk(txd == 1'b1, "R1 txd", txd, 1);
        reg_read(3'd0, v); chk(v == 0, "R1 buffer", v, 0);
        // R12 unused address, ignored write
        reg_read(3'd3, v); chk(v == 0, "R12 addr3", v, 0);
        reg_write(3'd5, 8'h00); #2 chk(rd_data == 8'h60, "R12 write ignored", rd_data, 8'h60);

        // R2 normal frames
        send_char(8'hA5, 1); send_char(8'h00, 1); send_char(8'hFF, 1);
        repeat (20) @(negedge clk);
        reg_read(3'd0, v); chk(v == 8'hA5, "R2 pop0", v, 8'hA5);
        reg_read(3'd0, v); chk(v == 8'h00, "R2 pop1", v, 8'h00);
        reg_read(3'd0, v); chk(v == 8'hFF, "R2 pop2", v, 8'hFF);

        // R3 glitch
        @(negedge clk); rxd_drv = 0; repeat (4) @(negedge clk); rxd_drv = 1;
        repeat (40) @(negedge clk);
        #2 chk(rd_data[0] == 0, "R3 glitch", rd_data[0], 0);

        // R4, R5 framing error then resync
        @(negedge clk);
        pend_cyc.push_back(cyc + LAT);          pend_ent.push_back({2'b01, 8'h3C});
        pend_cyc.push_back(cyc + LAT + 9*OVS);  pend_ent.push_back({2'b00, 8'h5A});
        drive_bits({13'd0, 1'b1, 8'h5A, 1'b0, 8'h3C, 1'b0}, 19);
        repeat (20) @(negedge clk);
        reg_read(3'd5, v); chk(v[3] == 1, "R4 fe", v[3], 1); chk(v[7] == 1, "R8 set", v[7], 1);
        reg_read(3'd5, v); chk(v[3] == 0, "R7 cleared", v[3], 0); chk(v[7] == 1, "R8 held", v[7], 1);
        reg_read(3'd0, v); chk(v == 8'h3C, "R4 data", v, 8'h3C);
        reg_read(3'd5, v); chk(v[7] == 1, "R8 last", v[7], 1);
        reg_read(3'd5, v); chk(v[7] == 0, "R8 clear", v[7], 0);
        reg_read(3'd0, v); chk(v == 8'h5A, "R5 resync", v, 8'h5A);

        // R6 break
        @(negedge clk);
        pend_cyc.push_back(cyc + LAT); pend_ent.push_back({2'b10, 8'h00});
        rxd_drv = 0; repeat (400) @(negedge clk); rxd_drv = 1;
        repeat (20) @(negedge clk);
        reg_read(3'd5, v); chk(v[4] == 1, "R6 break", v[4], 1);
        reg_read(3'd0, v); chk(v == 0, "R6 data", v, 0);
        #2 chk(rd_data[0] == 0, "R6 single entry", rd_data[0], 0);
        send_char(8'h81, 1); repeat (20) @(negedge clk);
        reg_read(3'd0, v); chk(v == 8'h81, "R6 after break", v, 8'h81);
        reg_read(3'd5, v);

        // R9 overrun
        for (int i = 0; i < 5; i++) send_char(8'h10 + 8'(i), 1);
        repeat (20) @(negedge clk);
        reg_read(3'd5, v); chk(v[1] == 1, "R9 overrun", v[1], 1);
        reg_read(3'd5, v); chk(v[1] == 0, "R9 cleared", v[1], 0);
        for (int i = 0; i < 4; i++) begin
            reg_read(3'd0, v); chk(v == 8'h10 + 8'(i), "R9 kept", v, 8'h10 + i);
        end
        #2 chk(rd_data[0] == 0, "R9 dropped", rd_data[0], 0);

        // R10, R11 transmit in loopback
        loop = 1;
        reg_write(3'd0, 8'h96);
        reg_write(3'd0, 8'h3B);
        #2 chk(rd_data[5] == 0, "R10 holding full", rd_data[5], 0);
        chk(rd_data[6] == 0, "R11 busy", rd_data[6], 0);
        repeat (2*TXLEN + 40) @(negedge clk);
        #2 chk(rd_data[6] == 1, "R11 idle", rd_data[6], 1);
        reg_read(3'd0, v); chk(v == 8'h96, "R11 loop0", v, 8'h96);
        reg_read(3'd0, v); chk(v == 8'h3B, "R11 loop1", v, 8'h3B);
        loop = 0;
        repeat (10) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule